// File: doc/BRIEF.md
# Page Remapping Table Cache

This block sits in front of the memory paths of a hybrid memory controller that keeps a fast DRAM tier and a slow NVM tier in one flat physical page space. When the controller swaps a whole page between the tiers, it records the swap as a pair of page numbers: one NVM page and one DRAM page that have traded places. Every memory request presents its physical page number to the block. One cycle later it gets back the page number it must really use, together with a hit flag and the tier that the returned page belongs to. A miss returns the request's own page number. Fetching missing pairs from a table held in memory happens outside the block.

The block is a set-associative cache of such pairs. The set is picked by the low bits of a page number and the rest of the page number is the stored tag. Both pages of a pair must therefore carry the same set bits, so that a lookup by either page reaches the same set. A lookup compares its tag against both stored fields of every way of the set, which gives translation in both directions. A separate install port writes a pair when a swap completes. An install that names a page already present reuses that entry. Otherwise it fills an empty way, or replaces the least recently used way of the set.

After reset a small state machine sweeps the table one set per cycle (state SWEEP) and clears the valid bits and the recency order. It then moves to state SERVE and stays there. The transitions are: SWEEP to SWEEP while sets remain, SWEEP to SERVE after the last set, and SERVE to SERVE. While the machine is in SWEEP, lookups always miss and installs are dropped.

Top module: `prt_remap_cache`

## Requirements
- R1: `table_ready` is 0 during reset. It reads 1 after exactly SETS rising clock edges following the release of reset, and once it is 1 it stays 1.
- R2: A lookup presented on a rising edge gives its result after that same edge: `res_valid` equals `lk_valid` at the previous edge, and it is 0 right after reset.
- R3: A lookup whose page equals the stored NVM page of a valid entry returns that entry's DRAM page, with `res_hit`=1 and `res_to_dram`=1.
- R4: A lookup whose page equals the stored DRAM page of a valid entry returns that entry's NVM page, with `res_hit`=1 and `res_to_dram`=0.
- R5: A lookup that matches no entry, or that arrives while `table_ready`=0, returns `res_ppn` equal to the requested page, with `res_hit`=0 and `res_to_dram`=0.
- R6: The set index is bits [IDX_W-1:0] of a page number (IDX_W = log2 SETS). An install whose two pages differ in those bits is dropped, and later lookups of either page miss.
- R7: An install that matches no entry writes the lowest-numbered empty way of the set. If the set is full, it replaces the way used least recently, where both installs and lookup hits count as uses.
- R8: An install whose NVM page or DRAM page equals a field of a valid entry in the set overwrites the lowest such entry. Any other entry that matched is invalidated, so lookups of its other page then miss.
- R9: A lookup and an install on the same edge: the lookup sees the table as it was before the install. If both touch the same set, only the install updates that set's recency order.
- R10: An install presented while `table_ready`=0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_ppn | input | PPN_W | Physical page number to translate |
| ins_valid | input | 1 | An install is presented this cycle |
| ins_nvm_ppn | input | PPN_W | NVM page of the pair to install |
| ins_dram_ppn | input | PPN_W | DRAM page of the pair to install |
| table_ready | output | 1 | Sweep finished; table is in service |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup matched an entry |
| res_to_dram | output | 1 | Returned page is the DRAM page of a pair |
| res_ppn | output | PPN_W | Page number the request must use |

## Verification
The bound checker watches the timing and the shape of every result on every cycle. It checks that results follow lookups by one cycle, that a miss passes the page through unchanged, that no hit appears before the sweep ends, that a hit keeps the set bits of the request, and that readiness never drops. What a hit returns, which way an install fills or evicts, how duplicate pairs are merged, and how same-edge lookups and installs interact all depend on the history of the table. Only the bench scenarios show these, by comparing against a reference table that keeps a use timestamp for every way.

// File: rtl/prt_pkg.sv
package prt_pkg;

    // Sweep controller states
    typedef enum logic {
        PRT_SWEEP = 1'b0,
        PRT_SERVE = 1'b1
    } prt_state_e;

endpackage

// File: rtl/prt_sweep_ctrl.sv
module prt_sweep_ctrl
    import prt_pkg::*;
#(
    parameter int SETS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic                    clr_en,
    output logic [$clog2(SETS)-1:0] clr_set,
    output logic                    ready
);
    localparam int IDX_W = $clog2(SETS);
    localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SETS - 1);

    prt_state_e       st_q;
    logic [IDX_W-1:0] cnt_q;

    // State register and sweep counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PRT_SWEEP;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                PRT_SWEEP: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_SET) st_q <= PRT_SERVE;
                end
                PRT_SERVE: st_q <= PRT_SERVE;
                default:   st_q <= PRT_SWEEP;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        clr_en  = 1'b0;
        ready   = 1'b0;
        clr_set = cnt_q;
        unique case (st_q)
            PRT_SWEEP: clr_en = 1'b1;
            PRT_SERVE: ready  = 1'b1;
            default:   clr_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/prt_way_match.sv
module prt_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 18
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][TAG_W-1:0] field_a,
    input  logic [WAYS-1:0][TAG_W-1:0] field_b,
    input  logic [TAG_W-1:0]           tag_a,
    input  logic [TAG_W-1:0]           tag_b,
    output logic [WAYS-1:0]            hit_a,
    output logic [WAYS-1:0]            hit_b
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_a[w] = vld[w] && (field_a[w] == tag_a);
        assign hit_b[w] = vld[w] && (field_b[w] == tag_b);
    end
endmodule

// File: rtl/prt_lru_age.sv
module prt_lru_age #(
    parameter int SETS = 4,
    parameter int WAYS = 4
) (
    input  logic                    clk,
    input  logic                    init_en,
    input  logic [$clog2(SETS)-1:0] init_set,
    input  logic                    ua_en,
    input  logic [$clog2(SETS)-1:0] ua_set,
    input  logic [$clog2(WAYS)-1:0] ua_way,
    input  logic                    ub_en,
    input  logic [$clog2(SETS)-1:0] ub_set,
    input  logic [$clog2(WAYS)-1:0] ub_way,
    input  logic [$clog2(SETS)-1:0] vic_set,
    output logic [$clog2(WAYS)-1:0] vic_way
);
    localparam int WAY_W = $clog2(WAYS);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    typedef logic [WAYS-1:0][WAY_W-1:0] age_row_t;

    // Ages form a permutation per set: 0 newest, WAYS-1 oldest
    age_row_t age_q [SETS];

    function automatic age_row_t bump(input age_row_t row, input logic [WAY_W-1:0] way);
        age_row_t nxt;
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == way)      nxt[w] = '0;
            else if (row[w] < row[way]) nxt[w] = row[w] + 1'b1;
            else                        nxt[w] = row[w];
        end
        return nxt;
    endfunction

    always_ff @(posedge clk) begin
        if (init_en) begin
            for (int w = 0; w < WAYS; w++) age_q[init_set][w] <= WAY_W'(w);
        end else begin
            if (ua_en) age_q[ua_set] <= bump(age_q[ua_set], ua_way);
            if (ub_en && !(ua_en && (ua_set == ub_set)))
                age_q[ub_set] <= bump(age_q[ub_set], ub_way);
        end
    end

    always_comb begin
        vic_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (age_q[vic_set][w] == OLDEST) vic_way = WAY_W'(w);
    end

endmodule

// File: rtl/prt_remap_cache.sv
module prt_remap_cache #(
    parameter int PPN_W = 20,
    parameter int SETS  = 4,
    parameter int WAYS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [PPN_W-1:0] lk_ppn,
    input  logic             ins_valid,
    input  logic [PPN_W-1:0] ins_nvm_ppn,
    input  logic [PPN_W-1:0] ins_dram_ppn,
    output logic             table_ready,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_to_dram,
    output logic [PPN_W-1:0] res_ppn
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = PPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [WAYS-1:0][TAG_W-1:0] tag_row_t;

    // Pair storage: swept clear, no reset on the arrays
    tag_row_t        nvm_tag_q  [SETS];
    tag_row_t        dram_tag_q [SETS];
    logic [WAYS-1:0] vld_q      [SETS];

    function automatic logic [WAY_W-1:0] low_idx(input logic [WAYS-1:0] v);
        logic [WAY_W-1:0] r;
        r = '0;
        for (int w = WAYS - 1; w >= 0; w--) if (v[w]) r = WAY_W'(w);
        return r;
    endfunction

    // ---------------- sweep controller ----------------
    logic             clr_en;
    logic [IDX_W-1:0] clr_set;

    prt_sweep_ctrl #(.SETS(SETS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (clr_en),
        .clr_set (clr_set),
        .ready   (table_ready)
    );

    // ---------------- lookup path ----------------
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  lk_hn, lk_hd;
    logic             lk_hit, lk_dir;
    logic [PPN_W-1:0] lk_out;
    logic [WAY_W-1:0] lk_way;

    assign lk_idx = lk_ppn[IDX_W-1:0];
    assign lk_tag = lk_ppn[PPN_W-1:IDX_W];

    prt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .vld     (vld_q[lk_idx]),
        .field_a (nvm_tag_q[lk_idx]),
        .field_b (dram_tag_q[lk_idx]),
        .tag_a   (lk_tag),
        .tag_b   (lk_tag),
        .hit_a   (lk_hn),
        .hit_b   (lk_hd)
    );

    always_comb begin
        lk_hit = 1'b0;
        lk_dir = 1'b0;
        lk_out = lk_ppn;
        lk_way = low_idx(lk_hn);
        if (table_ready) begin
            if (|lk_hn) begin
                lk_hit = 1'b1;
                lk_dir = 1'b1;
                lk_out = {dram_tag_q[lk_idx][lk_way], lk_idx};
            end else if (|lk_hd) begin
                lk_way = low_idx(lk_hd);
                lk_hit = 1'b1;
                lk_out = {nvm_tag_q[lk_idx][lk_way], lk_idx};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_hit     <= 1'b0;
            res_to_dram <= 1'b0;
            res_ppn     <= '0;
        end else begin
            res_valid   <= lk_valid;
            res_hit     <= lk_valid && lk_hit;
            res_to_dram <= lk_valid && lk_dir;
            res_ppn     <= lk_out;
        end
    end

    // ---------------- install path ----------------
    logic [IDX_W-1:0] ins_idx;
    logic [TAG_W-1:0] ins_ntag, ins_dtag;
    logic             ins_ok;
    logic [WAYS-1:0]  ins_hn, ins_hd, ins_any, tgt_oh, dup_mask;
    logic [WAY_W-1:0] tgt_way, lru_way;

    assign ins_idx  = ins_nvm_ppn[IDX_W-1:0];
    assign ins_ntag = ins_nvm_ppn[PPN_W-1:IDX_W];
    assign ins_dtag = ins_dram_ppn[PPN_W-1:IDX_W];
    assign ins_ok   = ins_valid && table_ready &&
                      (ins_nvm_ppn[IDX_W-1:0] == ins_dram_ppn[IDX_W-1:0]);

    prt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_ins_match (
        .vld     (vld_q[ins_idx]),
        .field_a (nvm_tag_q[ins_idx]),
        .field_b (dram_tag_q[ins_idx]),
        .tag_a   (ins_ntag),
        .tag_b   (ins_dtag),
        .hit_a   (ins_hn),
        .hit_b   (ins_hd)
    );

    prt_lru_age #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk      (clk),
        .init_en  (clr_en),
        .init_set (clr_set),
        .ua_en    (ins_ok),
        .ua_set   (ins_idx),
        .ua_way   (tgt_way),
        .ub_en    (lk_valid && lk_hit),
        .ub_set   (lk_idx),
        .ub_way   (lk_way),
        .vic_set  (ins_idx),
        .vic_way  (lru_way)
    );

    assign ins_any = ins_hn | ins_hd;

    always_comb begin
        if (|ins_any)                tgt_way = low_idx(ins_any);
        else if (!(&vld_q[ins_idx])) tgt_way = low_idx(~vld_q[ins_idx]);
        else                         tgt_way = lru_way;
    end

    assign tgt_oh   = WAYS'(1) << tgt_way;
    assign dup_mask = ins_any & ~tgt_oh;

    always_ff @(posedge clk) begin
        if (clr_en) begin
            vld_q[clr_set] <= '0;
        end else if (ins_ok) begin
            nvm_tag_q[ins_idx][tgt_way]  <= ins_ntag;
            dram_tag_q[ins_idx][tgt_way] <= ins_dtag;
            vld_q[ins_idx]               <= (vld_q[ins_idx] & ~dup_mask) | tgt_oh;
        end
    end

endmodule

// File: rtl/prt_remap_cache_chk.sv
module prt_remap_cache_chk #(
    parameter int PPN_W = 20,
    parameter int SETS  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [PPN_W-1:0] lk_ppn,
    input logic             table_ready,
    input logic             res_valid,
    input logic             res_hit,
    input logic             res_to_dram,
    input logic [PPN_W-1:0] res_ppn
);
    localparam int IDX_W = $clog2(SETS);

    // R1
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        table_ready |=> table_ready);

    // R2
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_valid == $past(lk_valid)));

    // R5
    miss_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_valid && !res_hit) |-> (res_ppn == $past(lk_ppn) && !res_to_dram));

    // R5
    no_hit_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(table_ready)) |-> !res_hit);

    // R6
    hit_keeps_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && res_hit) |-> (res_ppn[IDX_W-1:0] == $past(lk_ppn[IDX_W-1:0])));

    // R3
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit || res_to_dram) |-> res_valid);

endmodule

bind prt_remap_cache prt_remap_cache_chk #(.PPN_W(PPN_W), .SETS(SETS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_ppn      (lk_ppn),
    .table_ready (table_ready),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_to_dram (res_to_dram),
    .res_ppn     (res_ppn)
);

// File: tb/prt_remap_cache_tb.sv
`timescale 1ns/1ps
module prt_remap_cache_tb_top;
    localparam int PPN_W = 20;
    localparam int SETS  = 4;
    localparam int WAYS  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [PPN_W-1:0] lk_ppn = '0;
    logic             ins_valid = 1'b0;
    logic [PPN_W-1:0] ins_nvm_ppn = '0;
    logic [PPN_W-1:0] ins_dram_ppn = '0;
    logic             table_ready, res_valid, res_hit, res_to_dram;
    logic [PPN_W-1:0] res_ppn;

    int n_chk = 0;
    int n_bad = 0;
    int now_t = 1;
    bit done = 0;

    // Reference table
    logic             m_v  [SETS][WAYS];
    logic [PPN_W-1:0] m_n  [SETS][WAYS];
    logic [PPN_W-1:0] m_d  [SETS][WAYS];
    int               m_ts [SETS][WAYS];

    always #2 clk = ~clk;  // 250 MHz

    prt_remap_cache #(.PPN_W(PPN_W), .SETS(SETS), .WAYS(WAYS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ppn(lk_ppn),
        .ins_valid(ins_valid), .ins_nvm_ppn(ins_nvm_ppn), .ins_dram_ppn(ins_dram_ppn),
        .table_ready(table_ready), .res_valid(res_valid), .res_hit(res_hit),
        .res_to_dram(res_to_dram), .res_ppn(res_ppn)
    );

    // NVM pages carry top bit 1, DRAM pages top bit 0
    function automatic logic [PPN_W-1:0] nv(input int s, input int t);
        return {1'b1, 13'd0, 4'(t), 2'(s)};
    endfunction
    function automatic logic [PPN_W-1:0] dr(input int s, input int t);
        return {1'b0, 13'd0, 4'(t), 2'(s)};
    endfunction

    task automatic check(input string rq, input string what, input logic [PPN_W-1:0] act,
                         input logic [PPN_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One cycle: drive lookup and install, compare result, update reference
    task automatic step(input logic lv, input logic [PPN_W-1:0] lp, input logic iv,
                        input logic [PPN_W-1:0] in_p, input logic [PPN_W-1:0] id_p,
                        input string tag);
        logic eh, et;
        logic [PPN_W-1:0] ep;
        int hs, hw, s, tgt;
        bit iok;
        string rq;
        @(negedge clk);
        lk_valid = lv; lk_ppn = lp; ins_valid = iv; ins_nvm_ppn = in_p; ins_dram_ppn = id_p;
        eh = 0; et = 0; ep = lp; hs = int'(lp[1:0]); hw = -1;
        if (lv) begin
            for (int w = 0; w < WAYS; w++)
                if (hw < 0 && m_v[hs][w] && m_n[hs][w] == lp) begin
                    hw = w; eh = 1; et = 1; ep = m_d[hs][w];
                end
            for (int w = 0; w < WAYS; w++)
                if (hw < 0 && m_v[hs][w] && m_d[hs][w] == lp) begin
                    hw = w; eh = 1; et = 0; ep = m_n[hs][w];
                end
        end
        rq = tag;
        if (rq == "") rq = !lv ? "R2" : (eh ? (et ? "R3" : "R4") : "R5");
        @(posedge clk); #1;
        check("R2", "res_valid", PPN_W'(res_valid), PPN_W'(lv));
        if (lv) begin
            check(rq, "res_hit", PPN_W'(res_hit), PPN_W'(eh));
            check(rq, "res_to_dram", PPN_W'(res_to_dram), PPN_W'(et));
            check(rq, "res_ppn", res_ppn, ep);
        end
        // reference update: install first, then lookup recency
        iok = iv && (in_p[1:0] == id_p[1:0]);
        s = int'(in_p[1:0]);
        if (iok) begin
            tgt = -1;
            for (int w = 0; w < WAYS; w++)
                if (m_v[s][w] && (m_n[s][w] == in_p || m_d[s][w] == id_p)) begin
                    if (tgt < 0) tgt = w; else m_v[s][w] = 0;
                end
            for (int w = 0; w < WAYS; w++) if (tgt < 0 && !m_v[s][w]) tgt = w;
            if (tgt < 0) begin
                tgt = 0;
                for (int w = 1; w < WAYS; w++) if (m_ts[s][w] < m_ts[s][tgt]) tgt = w;
            end
            m_v[s][tgt] = 1; m_n[s][tgt] = in_p; m_d[s][tgt] = id_p; m_ts[s][tgt] = now_t;
        end
        if (eh && !(iok && s == hs)) m_ts[hs][hw] = now_t;
        now_t++;
    endtask

    task automatic look(input logic [PPN_W-1:0] p, input string tag);
        step(1, p, 0, '0, '0, tag);
    endtask
    task automatic put(input logic [PPN_W-1:0] a, input logic [PPN_W-1:0] b, input string tag);
        step(0, '0, 1, a, b, tag);
    endtask

    initial begin
        void'($urandom(32'h1a2b3c4d));
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_v[s][w] = 0; m_n[s][w] = '0; m_d[s][w] = '0; m_ts[s][w] = 0;
            end
        repeat (3) @(posedge clk);
        #1;
        check("R1", "table_ready in reset", PPN_W'(table_ready), '0);
        check("R2", "res_valid in reset", PPN_W'(res_valid), '0);
        // Release reset with lookup and install pending during the sweep
        @(negedge clk);
        rst_n = 1'b1;
        lk_valid = 1; lk_ppn = nv(1, 5);
        ins_valid = 1; ins_nvm_ppn = nv(1, 5); ins_dram_ppn = dr(1, 5);
        for (int i = 1; i <= SETS; i++) begin
            @(posedge clk); #1;
            check("R1", "table_ready during sweep", PPN_W'(table_ready), PPN_W'(i == SETS));
            check("R5", "hit while sweeping", PPN_W'(res_hit), '0);
            check("R5", "passthrough while sweeping", res_ppn, nv(1, 5));
        end
        step(0, '0, 0, '0, '0, "");
        look(nv(1, 5), "R10");
        check("R1", "table_ready held", PPN_W'(table_ready), 1);

        // Both translation directions and a miss
        put(nv(1, 2), dr(1, 9), "R7");
        look(nv(1, 2), "R3");
        look(dr(1, 9), "R4");
        look(nv(1, 3), "R5");

        // Same-edge lookup and install
        step(1, nv(2, 4), 1, nv(2, 4), dr(2, 4), "R9");
        look(nv(2, 4), "R9");

        // Index mismatch is dropped
        put(nv(3, 6), dr(0, 6), "R6");
        look(nv(3, 6), "R6");
        look(dr(0, 6), "R6");

        // LRU eviction in set 0
        for (int t = 0; t < 4; t++) put(nv(0, t), dr(0, t + 8), "R7");
        look(nv(0, 0), "R7");
        put(nv(0, 4), dr(0, 12), "R7");
        look(nv(0, 1), "R7");
        look(nv(0, 0), "R7");
        look(dr(0, 12), "R7");

        // Same-set same-edge: lookup touch dropped in favour of install
        step(1, nv(0, 2), 1, nv(0, 5), dr(0, 13), "R9");
        look(nv(0, 2), "R9");

        // Overlapping installs
        put(nv(1, 2), dr(1, 10), "R8");
        look(dr(1, 9), "R8");
        look(nv(1, 2), "R8");
        put(nv(2, 7), dr(2, 7), "R8");
        put(nv(2, 4), dr(2, 7), "R8");
        look(nv(2, 7), "R8");
        look(dr(2, 7), "R8");
        look(dr(2, 4), "R8");

        // Constrained random traffic
        for (int k = 0; k < 3000; k++) begin
            int r, s, t;
            logic lv, iv;
            logic [PPN_W-1:0] lp, a, b;
            r  = $urandom_range(0, 99);
            s  = $urandom_range(0, SETS - 1);
            t  = $urandom_range(0, 15);
            lv = ($urandom_range(0, 99) < 80);
            lp = (r < 45) ? nv(s, t) : (r < 90) ? dr(s, t) : PPN_W'($urandom);
            iv = ($urandom_range(0, 99) < 30);
            s  = $urandom_range(0, SETS - 1);
            a  = nv(s, $urandom_range(0, 15));
            b  = dr(($urandom_range(0, 9) == 0) ? $urandom_range(0, SETS - 1) : s,
                    $urandom_range(0, 15));
            step(lv, lp, iv, a, b, "");
        end
        step(0, '0, 0, '0, '0, "");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule